// File: doc/BRIEF.md
# Serial Register Map Front End With Counter Snapshot

This block is the slave side of a two-wire serial bus in front of a sixteen-byte register map. It recognises its own device address and takes the first data byte of a write transfer as a word pointer. It then moves bytes between the bus and the map, advancing the pointer by one after every data byte in either direction. Location 00h is a control byte held in the block. Locations 08h to 0Fh are eight general bytes, also held here. Locations 01h to 07h belong to an external set of time counters.

The counters keep running while the bus is busy. So that a multi-byte read never sees a carry ripple partway through, the block copies every counter byte into a bank of capture latches when it accepts a read address. All counter bytes of that read are served from the copy. Writes to a counter location leave the block as a one-hot strobe with one byte of data, so the counter logic can load exactly one register. When the masking bit of the control byte is set, the upper fields of the date and month bytes read back as zero, which leaves plain BCD date and month values.

Both bus lines pass through two-flop synchronisers on the system clock before any edge or bus condition is decoded. The data line is driven through an active-high pull-low enable.

Top module: `serial_regmap_port`

## Requirements
- R1: The address byte A2h (write) and A3h (read) is acknowledged by pulling the data line low in the ninth clock; any other address byte gets no acknowledge, and the rest of that transfer is ignored.
- R2: In a write transfer, the first byte after the address loads the word pointer from its low four bits; the upper four bits have no effect.
- R3: The pointer goes up by one after every data byte written (other than the pointer byte) and after every data byte read, and it wraps from 0Fh to 00h.
- R4: A write to 00h updates the control byte on `ctrl_o`. A write to 08h–0Fh is stored in the block. A write to location k in 01h–07h raises bit k−1 of `cnt_we_o` for one cycle, with the byte on `cnt_wdata_o`. A read returns the current value of each location.
- R5: A write to one counter location strobes only that location; at most one bit of `cnt_we_o` is ever high.
- R6: When a read address is accepted, all seven counter bytes of `cnt_live_i` (location k at bits 8k−1 down to 8k−8) are captured, and every counter byte of that read comes from the capture, even if the live values change during the read.
- R7: While bit 3 of the control byte is 1, reads of 05h return bits 7:6 as 0 and reads of 06h return bits 7:5 as 0; the other bits and all other locations are unchanged. With the bit at 0, reads are unmasked.
- R8: Every byte written to the device after its address, including the pointer byte, is acknowledged.
- R9: Read data is sent MSB first. When the master does not acknowledge a read byte, the block stops driving the line until the next START, and a STOP always releases the line.
- R10: After reset the data line is released, the control byte is 00h and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| cnt_live_i | input | 56 | Live counter bytes, location k in byte k−1 |
| cnt_we_o | output | 7 | One-hot write strobe, bit k−1 for location k |
| cnt_wdata_o | output | 8 | Byte written to the strobed counter |
| ctrl_o | output | 8 | Control byte (location 00h) |

## Verification
The map is swept by a sixteen-byte burst write from pointer 00h with a per-location value pattern, then read back in one burst. This separates wrong increment, wrong decode and crossed write strobes. A second burst starts at a pointer with its upper bits set and runs past 0Fh, and a read starts at 0Eh, so pointer truncation and wrap are both seen in each direction. The capture is tested by inverting every live counter byte after the first byte of a read: stale and torn results look different. The mask is read with the flag set and cleared. Foreign addresses, a lone counter write and a NACK followed by extra clocks show what must stay untouched or released.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

    localparam int DW        = 8;
    localparam int AW        = 4;
    localparam int NCNT      = 7;
    localparam int MAP_N     = 1 << AW;
    localparam int RAM_BASE  = NCNT + 1;
    localparam int RAM_N     = MAP_N - RAM_BASE;
    localparam int CW        = $clog2(DW + 1);

    localparam logic [6:0] DEV_ADDR = 7'h51;

    localparam int MASK_BIT  = 3;
    localparam int DATE_LOC  = 5;
    localparam int WDAY_LOC  = 6;
    localparam logic [DW-1:0] DATE_KEEP = 8'h3F;
    localparam logic [DW-1:0] WDAY_KEEP = 8'h1F;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK
    } eng_state_e;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic [DW-1:0] mask_read(
        input logic [AW-1:0] addr,
        input logic [DW-1:0] data,
        input logic          mask_on
    );
        logic [DW-1:0] r;
        r = data;
        if (mask_on) begin
            if (addr == AW'(DATE_LOC)) r = data & DATE_KEEP;
            if (addr == AW'(WDAY_LOC)) r = data & WDAY_KEEP;
        end
        return r;
    endfunction

endpackage

// File: rtl/rmp_sync_detect.sv
module rmp_sync_detect
    import rmp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_sr, sda_sr;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_sr[STAGES-1];
    assign sda_s = sda_sr[STAGES-1];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/rmp_byte_engine.sv
module rmp_byte_engine
    import rmp_pkg::*;
#(
    parameter logic [6:0] ADDR7 = DEV_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output wr_req_t       wr,
    output logic          cap_stb,
    output logic [AW-1:0] ptr,
    output logic          ptr_inc,
    output logic          ptr_load
);

    eng_state_e    state;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] obuf;
    logic          rw;
    logic          first;
    logic          mst_ack;

    logic rx_done, addr_hit, rd_adv, is_rx;

    always_comb begin
        is_rx    = (state == S_ADDR) || (state == S_WR);
        rx_done  = ev.scl_fall && is_rx && (bitcnt == CW'(DW));
        addr_hit = (shreg[DW-1:1] == ADDR7);
        rd_adv   = ev.scl_fall && (state == S_RD) && (bitcnt == CW'(DW - 1));
        ptr_load = rx_done && (state == S_WR) && first;
        wr.en    = rx_done && (state == S_WR) && !first;
        wr.addr  = ptr;
        wr.data  = shreg;
        ptr_inc  = wr.en || rd_adv;
        cap_stb  = rx_done && (state == S_ADDR) && addr_hit && shreg[0];
    end

    // pointer: only the low address bits of the pointer byte are kept
    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (ptr_load) ptr <= shreg[AW-1:0];
        else if (ptr_inc)  ptr <= ptr + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            obuf    <= '0;
            rw      <= 1'b0;
            first   <= 1'b0;
            sda_oe  <= 1'b0;
            mst_ack <= 1'b0;
        end else if (ev.start) begin
            state  <= S_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                S_ADDR, S_WR: begin
                    if (ev.scl_rise && bitcnt != CW'(DW)) begin
                        shreg  <= {shreg[DW-2:0], ev.sda};
                        bitcnt <= bitcnt + CW'(1);
                    end else if (rx_done) begin
                        if (state == S_ADDR) begin
                            if (addr_hit) begin
                                state  <= S_ADDR_ACK;
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                first  <= ~shreg[0];
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            state  <= S_WR_ACK;
                            sda_oe <= 1'b1;
                            first  <= 1'b0;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            obuf   <= rd_data;
                            sda_oe <= ~rd_data[DW-1];
                            state  <= S_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= S_WR;
                        end
                    end
                end
                S_WR_ACK: begin
                    if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= S_WR;
                    end
                end
                S_RD: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == CW'(DW - 1)) begin
                            sda_oe <= 1'b0;
                            state  <= S_RD_ACK;
                        end else begin
                            obuf   <= {obuf[DW-2:0], 1'b0};
                            sda_oe <= ~obuf[DW-2];
                            bitcnt <= bitcnt + CW'(1);
                        end
                    end
                end
                S_RD_ACK: begin
                    if (ev.scl_rise) begin
                        mst_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mst_ack) begin
                            obuf   <= rd_data;
                            sda_oe <= ~rd_data[DW-1];
                            bitcnt <= '0;
                            state  <= S_RD;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rmp_regfile.sv
module rmp_regfile
    import rmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr,
    input  logic               cap_stb,
    input  logic [AW-1:0]      rd_ptr,
    input  logic [NCNT*DW-1:0] cnt_live,
    output logic [DW-1:0]      rd_data,
    output logic [NCNT-1:0]    cnt_we,
    output logic [DW-1:0]      cnt_wdata,
    output logic [DW-1:0]      ctrl
);

    logic [DW-1:0] cap_q    [NCNT];
    logic [DW-1:0] ram_q    [RAM_N];
    logic [DW-1:0] map_view [MAP_N];

    always_ff @(posedge clk) begin
        if (rst)                           ctrl <= '0;
        else if (wr.en && wr.addr == '0)   ctrl <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_wdata <= '0;
        else     cnt_wdata <= wr.data;
    end

    assign map_view[0] = ctrl;

    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)          cap_q[k] <= '0;
            else if (cap_stb) cap_q[k] <= cnt_live[k*DW +: DW];
        end
        always_ff @(posedge clk) begin
            if (rst) cnt_we[k] <= 1'b0;
            else     cnt_we[k] <= wr.en && (wr.addr == AW'(k + 1));
        end
        assign map_view[k + 1] = cap_q[k];
    end

    for (genvar j = 0; j < RAM_N; j++) begin : g_ram
        always_ff @(posedge clk) begin
            if (rst)                                       ram_q[j] <= '0;
            else if (wr.en && wr.addr == AW'(RAM_BASE + j)) ram_q[j] <= wr.data;
        end
        assign map_view[RAM_BASE + j] = ram_q[j];
    end

    assign rd_data = mask_read(rd_ptr, map_view[rd_ptr], ctrl[MASK_BIT]);

endmodule

// File: rtl/serial_regmap_port.sv
module serial_regmap_port
    import rmp_pkg::*;
#(
    parameter logic [6:0] ADDR7       = DEV_ADDR,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [NCNT*DW-1:0] cnt_live_i,
    output logic [NCNT-1:0]    cnt_we_o,
    output logic [DW-1:0]      cnt_wdata_o,
    output logic [DW-1:0]      ctrl_o
);

    bus_ev_t       ev;
    wr_req_t       wr;
    logic          cap_stb;
    logic [AW-1:0] ptr;
    logic          ptr_inc, ptr_load;
    logic [DW-1:0] rd_data;
    logic          stop_evt;

    assign stop_evt = ev.stop;

    rmp_sync_detect #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    rmp_byte_engine #(.ADDR7(ADDR7)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe_o),
        .wr       (wr),
        .cap_stb  (cap_stb),
        .ptr      (ptr),
        .ptr_inc  (ptr_inc),
        .ptr_load (ptr_load)
    );

    rmp_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .cap_stb   (cap_stb),
        .rd_ptr    (ptr),
        .cnt_live  (cnt_live_i),
        .rd_data   (rd_data),
        .cnt_we    (cnt_we_o),
        .cnt_wdata (cnt_wdata_o),
        .ctrl      (ctrl_o)
    );

endmodule

// File: rtl/rmp_checker.sv
module rmp_checker
    import rmp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            sda_oe,
    input logic [NCNT-1:0] cnt_we,
    input logic [DW-1:0]   ctrl,
    input logic            stop_evt,
    input logic            cap_stb,
    input logic [AW-1:0]   ptr,
    input logic            ptr_inc,
    input logic            ptr_load
);

    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!sda_oe && ctrl == '0 && ptr == '0));

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
        ptr_inc |=> ptr == $past(ptr) + AW'(1));

    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (!ptr_inc && !ptr_load) |=> $stable(ptr));

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_we));

    a_r9_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    a_r6_capture_bus_free: assert property (@(posedge clk) disable iff (rst)
        cap_stb |-> !sda_oe);

endmodule

bind serial_regmap_port rmp_checker u_rmp_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe_o),
    .cnt_we   (cnt_we_o),
    .ctrl     (ctrl_o),
    .stop_evt (stop_evt),
    .cap_stb  (cap_stb),
    .ptr      (ptr),
    .ptr_inc  (ptr_inc),
    .ptr_load (ptr_load)
);

// File: tb/serial_regmap_port_bench.sv
module serial_regmap_port_bench;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [55:0] cnt_live;
    logic [6:0]  cnt_we;
    logic [7:0]  cnt_wdata;
    logic [7:0]  ctrl;

    logic [7:0] cnt_m [7];
    logic [7:0] bump  [7];
    logic [7:0] exp_m [16];
    logic [7:0] wbuf  [16];
    logic [7:0] rbuf  [16];

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    bit bump_mid = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_oe ? 1'b0 : m_sda;

    serial_regmap_port u_serial_regmap_port (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .cnt_live_i  (cnt_live),
        .cnt_we_o    (cnt_we),
        .cnt_wdata_o (cnt_wdata),
        .ctrl_o      (ctrl)
    );

    always @(posedge clk) begin
        for (int k = 0; k < 7; k++)
            if (rst) cnt_m[k] <= 8'h00;
            else if (cnt_we[k]) cnt_m[k] <= cnt_wdata;
    end

    always_comb begin
        for (int k = 0; k < 7; k++) cnt_live[k*8 +: 8] = cnt_m[k] ^ bump[k];
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int loc);
        logic [7:0] v;
        if (loc >= 1 && loc <= 7) v = cnt_m[loc-1] ^ bump[loc-1];
        else v = exp_m[loc];
        if (exp_m[0][3] && loc == 5) v = v & 8'h3F;
        if (exp_m[0][3] && loc == 6) v = v & 8'h1F;
        return v;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q);
        m_sda = 1'b1; wt(Q);
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q/2);
        b = sda_line; wt(Q/2); m_scl = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            d[i] = b;
        end
        bit_out(last);
    endtask

    // R1 R2 R8: burst write of wbuf[0..n-1] from pointer byte p
    task automatic wr_regs(input logic [7:0] p, input int n);
        logic ack;
        bus_start();
        send_byte(8'hA2, ack); chk("R1 write address ack", 8'(ack), 8'h01);
        send_byte(p, ack);     chk("R8 pointer byte ack", 8'(ack), 8'h01);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk("R8 data byte ack", 8'(ack), 8'h01);
            exp_m[(p[3:0] + k) % 16] = wbuf[k];
        end
        bus_stop();
        wt(4);
    endtask

    // R1 R9: set pointer, repeated start, burst read n bytes into rbuf
    task automatic rd_regs(input logic [7:0] p, input int n);
        logic ack;
        bus_start();
        send_byte(8'hA2, ack); chk("R1 write address ack", 8'(ack), 8'h01);
        send_byte(p, ack);     chk("R8 pointer byte ack", 8'(ack), 8'h01);
        bus_start();
        send_byte(8'hA3, ack); chk("R1 read address ack", 8'(ack), 8'h01);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, rbuf[k]);
            if (k == 0 && bump_mid)
                for (int j = 0; j < 7; j++) bump[j] = 8'hFF;
        end
        bus_stop();
        wt(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] snap [7];
        for (int k = 0; k < 7; k++) bump[k] = 8'h00;
        for (int k = 0; k < 16; k++) exp_m[k] = 8'h00;
        wt(5);
        rst = 1'b0;
        wt(2);

        // R10 reset state
        chk("R10 data line released", 8'(sda_oe), 8'h00);
        chk("R10 control byte", ctrl, 8'h00);
        rd_regs(8'h00, 1);
        chk("R10 location 0 after reset", rbuf[0], 8'h00);

        // R4 R3 full map sweep write then burst read
        for (int k = 0; k < 16; k++) wbuf[k] = 8'(k * 29 + 64) & 8'hF7;
        wr_regs(8'h00, 16);
        chk("R4 control output", ctrl, wbuf[0]);
        for (int k = 0; k < 7; k++) chk("R4 counter strobe data", cnt_m[k], wbuf[k+1]);
        rd_regs(8'h00, 16);
        for (int k = 0; k < 16; k++) chk("R3 R4 burst readback", rbuf[k], exp_read(k));

        // R2 R3 upper pointer bits ignored, write wraps past 0Fh
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'hA0 + k);
        wbuf[7] = 8'h00;
        wr_regs(8'h39, 8);
        chk("R2 R3 wrap wrote control", ctrl, 8'h00);
        rd_regs(8'hE9, 7);
        for (int k = 0; k < 7; k++) chk("R2 R3 readback at 9..F", rbuf[k], exp_read(9 + k));
        rd_regs(8'h0E, 3);
        chk("R3 read wrap 0E", rbuf[0], exp_read(14));
        chk("R3 read wrap 0F", rbuf[1], exp_read(15));
        chk("R3 read wrap 00", rbuf[2], exp_read(0));

        // R1 foreign addresses are not acknowledged and change nothing
        bus_start();
        send_byte(8'hA4, ack); chk("R1 foreign address no ack", 8'(ack), 8'h00);
        send_byte(8'h0A, ack); chk("R1 ignored byte no ack", 8'(ack), 8'h00);
        send_byte(8'h55, ack);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ack); chk("R1 foreign address no ack", 8'(ack), 8'h00);
        send_byte(8'h00, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        wt(4);
        rd_regs(8'h0A, 1);
        chk("R1 location 0A untouched", rbuf[0], exp_read(10));
        chk("R1 control untouched", ctrl, 8'h00);

        // R5 single counter write leaves the others
        for (int k = 0; k < 7; k++) snap[k] = cnt_m[k];
        wbuf[0] = 8'hEE;
        wr_regs(8'h03, 1);
        for (int k = 0; k < 7; k++)
            chk("R5 single counter write", cnt_m[k], (k == 2) ? 8'hEE : snap[k]);

        // R6 capture at read start; live values flip after first byte
        for (int k = 0; k < 7; k++) snap[k] = cnt_m[k];
        bump_mid = 1;
        rd_regs(8'h01, 7);
        bump_mid = 0;
        for (int k = 0; k < 7; k++) chk("R6 snapshot used for whole read", rbuf[k], snap[k]);
        rd_regs(8'h02, 1);
        chk("R6 next read sees new value", rbuf[0], snap[1] ^ 8'hFF);
        for (int k = 0; k < 7; k++) bump[k] = 8'h00;

        // R7 masking of date and month bytes
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
        wr_regs(8'h05, 2);
        wbuf[0] = 8'h08;
        wr_regs(8'h00, 1);
        rd_regs(8'h04, 4);
        chk("R7 unmasked neighbour 04", rbuf[0], cnt_m[3]);
        chk("R7 masked 05", rbuf[1], 8'h3F);
        chk("R7 masked 06", rbuf[2], 8'h1F);
        chk("R7 unmasked neighbour 07", rbuf[3], cnt_m[6]);
        wbuf[0] = 8'h00;
        wr_regs(8'h00, 1);
        rd_regs(8'h05, 2);
        chk("R7 mask off 05", rbuf[0], 8'hFF);
        chk("R7 mask off 06", rbuf[1], 8'hFF);

        // R9 NACK releases the line; MSB first checked via value
        wbuf[0] = 8'h81;
        wr_regs(8'h0C, 1);
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'h0C, ack);
        bus_start();
        send_byte(8'hA3, ack);
        recv_byte(1'b1, rbuf[0]);
        chk("R9 MSB first data", rbuf[0], 8'h81);
        recv_byte(1'b1, rbuf[1]);
        chk("R9 released after NACK", rbuf[1], 8'hFF);
        bus_stop();
        wt(4);
        chk("R9 released after STOP", 8'(sda_oe), 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule